// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the control unit of a small accumulator processor with a 16-bit instruction word. It is a single Moore machine with a 4-bit state register. The machine fetches an instruction over a request/wait memory handshake and branches on the two opcode bits to one of four execution paths: load, store, add and conditional branch on the accumulator sign. It then returns to fetch. Every register-transfer strobe and memory control line is decoded from the registered state alone.

The external reset and the memory wait line each pass through one flip-flop before the sequencer uses them, so the sequencer reacts to both one cycle late. The opcode bits and the accumulator sign come straight from datapath registers and are used without a delay stage. The datapath itself (program counter, memory address and buffer registers, instruction register, accumulator) sits outside this block and acts on the strobes.

Top module: `acc_ctrl_fsm`

## Requirements
- R1: The state is visible on `ctl_state` with these codes: RES 0, IF0 1, IF1 2, IF2 3, IF3 4, OD 5, LD0 6, LD1 7, LD2 8, ST0 9, ST1 10, AD0 11, AD1 12, AD2 13, BR0 14, BR1 15.
- R2: `rst_in` is synchronous and active high and is registered once. While the registered copy is high the next state is RES, whatever the current state. RES goes to IF0 once the registered copy is low. A reset raised in any state therefore takes effect after the second rising edge.
- R3: IF0 goes to IF1. IF1 stays until the registered wait is high and then goes to IF2. IF2 stays while the registered wait is high and goes to IF3 when it is low. IF3 goes to OD.
- R4: OD picks the next state from `ir_op`: 00 gives LD0, 01 gives ST0, 10 gives AD0, 11 gives BR0.
- R5: Load runs LD0 to LD1. LD1 stays while the registered wait is high and goes to LD2 when it is low. LD2 goes to IF0.
- R6: Store runs ST0 to ST1. ST1 stays while the registered wait is high and goes to IF0 when it is low.
- R7: Add runs AD0 to AD1 to AD2 to IF0. AD1 waits exactly as LD1 does.
- R8: BR0 goes to IF0 when `acc_sign` is 0 and to BR1 when it is 1. BR1 goes to IF0.
- R9: `mem_wait_in` is registered once, so a level driven before edge k steers the transition taken at edge k+1.
- R10: The strobes depend on the state only. RES: pc_clear. IF0: pc_incr and pc_to_mar. IF1: mem_req. IF2, LD1 and AD1: mem_req and mem_to_mbr. IF3: mbr_to_ir. LD0 and AD0: iraddr_to_mar. LD2: mbr_to_acc. ST0: iraddr_to_mar and acc_to_mbr. ST1: mem_req and mem_write. AD2: acc_add. BR1: iraddr_to_pc. OD and BR0: none. All other strobes are low in each state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_in | input | 1 | Synchronous active-high reset, registered once |
| mem_wait_in | input | 1 | Memory busy handshake, registered once |
| ir_op | input | 2 | Opcode field of the instruction register |
| acc_sign | input | 1 | Sign bit of the accumulator |
| ctl_state | output | 4 | Current state code |
| pc_clear | output | 1 | Clear the program counter |
| pc_incr | output | 1 | Increment the program counter |
| pc_to_mar | output | 1 | Copy program counter into address register |
| mbr_to_ir | output | 1 | Copy buffer register into instruction register |
| mbr_to_acc | output | 1 | Copy buffer register into accumulator |
| acc_to_mbr | output | 1 | Copy accumulator into buffer register |
| acc_add | output | 1 | Accumulator takes accumulator plus buffer |
| iraddr_to_mar | output | 1 | Copy instruction address field into address register |
| iraddr_to_pc | output | 1 | Copy instruction address field into program counter |
| mem_to_mbr | output | 1 | Capture memory read data into buffer register |
| mem_req | output | 1 | Memory request |
| mem_write | output | 1 | Request is a write (low means read) |

## Verification
The hardest cases to reach are the ones where the one-cycle delay on the wait line matters: a wait pulse that is seen in IF1 but has already fallen when IF2 is evaluated, and a reset raised in the middle of a handshake that must not act for one more edge. The stimulus table drives wait levels row by row, so each expected state follows from the level set one row earlier. Directed runs then raise reset inside IF2 with wait held high, and change the opcode and sign between edges while in OD to show that the strobes do not react.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

    localparam int STATE_W = 4;
    localparam int OP_W    = 2;

    typedef enum logic [STATE_W-1:0] {
        S_RES = 4'd0,  S_IF0 = 4'd1,  S_IF1 = 4'd2,  S_IF2 = 4'd3,
        S_IF3 = 4'd4,  S_OD  = 4'd5,  S_LD0 = 4'd6,  S_LD1 = 4'd7,
        S_LD2 = 4'd8,  S_ST0 = 4'd9,  S_ST1 = 4'd10, S_AD0 = 4'd11,
        S_AD1 = 4'd12, S_AD2 = 4'd13, S_BR0 = 4'd14, S_BR1 = 4'd15
    } ctl_state_e;

    typedef struct packed {
        logic pc_clear;
        logic pc_incr;
        logic pc_to_mar;
        logic mbr_to_ir;
        logic mbr_to_acc;
        logic acc_to_mbr;
        logic acc_add;
        logic iraddr_to_mar;
        logic iraddr_to_pc;
        logic mem_to_mbr;
        logic mem_req;
        logic mem_write;
    } strobes_t;

    typedef struct packed {
        ctl_state_e state;
    } ctl_regs_t;

endpackage

// File: rtl/ctl_in_sync.sv
module ctl_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [WIDTH-1:0] pipe_d [STAGES];
            logic [WIDTH-1:0] pipe_q [STAGES];
            for (genvar g = 0; g < STAGES; g++) begin : g_stage
                if (g == 0) begin : g_first
                    always_comb pipe_d[g] = async_i;
                end else begin : g_next
                    always_comb pipe_d[g] = pipe_q[g-1];
                end
                always_ff @(posedge clk) begin
                    pipe_q[g] <= pipe_d[g];
                end
            end
            assign sync_o = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ctl_next_state.sv
module ctl_next_state
    import acc_ctrl_pkg::*;
(
    input  ctl_state_e        state_i,
    input  logic              rst_s_i,
    input  logic              wait_s_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              sign_i,
    output ctl_state_e        state_o
);
    ctl_state_e dispatch;

    always_comb begin
        case (op_i)
            2'b00:   dispatch = S_LD0;
            2'b01:   dispatch = S_ST0;
            2'b10:   dispatch = S_AD0;
            default: dispatch = S_BR0;
        endcase
    end

    always_comb begin
        state_o = state_i;
        if (rst_s_i) begin
            state_o = S_RES;
        end else begin
            case (state_i)
                S_RES: state_o = S_IF0;
                S_IF0: state_o = S_IF1;
                S_IF1: state_o = wait_s_i ? S_IF2 : S_IF1;
                S_IF2: state_o = wait_s_i ? S_IF2 : S_IF3;
                S_IF3: state_o = S_OD;
                S_OD:  state_o = dispatch;
                S_LD0: state_o = S_LD1;
                S_LD1: state_o = wait_s_i ? S_LD1 : S_LD2;
                S_LD2: state_o = S_IF0;
                S_ST0: state_o = S_ST1;
                S_ST1: state_o = wait_s_i ? S_ST1 : S_IF0;
                S_AD0: state_o = S_AD1;
                S_AD1: state_o = wait_s_i ? S_AD1 : S_AD2;
                S_AD2: state_o = S_IF0;
                S_BR0: state_o = sign_i ? S_BR1 : S_IF0;
                S_BR1: state_o = S_IF0;
                default: state_o = S_RES;
            endcase
        end
    end
endmodule

// File: rtl/ctl_strobe_dec.sv
module ctl_strobe_dec
    import acc_ctrl_pkg::*;
(
    input  ctl_state_e state_i,
    output strobes_t   strb_o
);
    always_comb begin
        strb_o = '0;
        case (state_i)
            S_RES: strb_o.pc_clear = 1'b1;
            S_IF0: begin
                strb_o.pc_incr   = 1'b1;
                strb_o.pc_to_mar = 1'b1;
            end
            S_IF1: strb_o.mem_req = 1'b1;
            S_IF2, S_LD1, S_AD1: begin
                strb_o.mem_req    = 1'b1;
                strb_o.mem_to_mbr = 1'b1;
            end
            S_IF3: strb_o.mbr_to_ir = 1'b1;
            S_LD0, S_AD0: strb_o.iraddr_to_mar = 1'b1;
            S_LD2: strb_o.mbr_to_acc = 1'b1;
            S_ST0: begin
                strb_o.iraddr_to_mar = 1'b1;
                strb_o.acc_to_mbr    = 1'b1;
            end
            S_ST1: begin
                strb_o.mem_req   = 1'b1;
                strb_o.mem_write = 1'b1;
            end
            S_AD2: strb_o.acc_add = 1'b1;
            S_BR1: strb_o.iraddr_to_pc = 1'b1;
            default: strb_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_ctrl_fsm.sv
module acc_ctrl_fsm
    import acc_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_in,
    input  logic                mem_wait_in,
    input  logic [OP_W-1:0]     ir_op,
    input  logic                acc_sign,
    output logic [STATE_W-1:0]  ctl_state,
    output logic                pc_clear,
    output logic                pc_incr,
    output logic                pc_to_mar,
    output logic                mbr_to_ir,
    output logic                mbr_to_acc,
    output logic                acc_to_mbr,
    output logic                acc_add,
    output logic                iraddr_to_mar,
    output logic                iraddr_to_pc,
    output logic                mem_to_mbr,
    output logic                mem_req,
    output logic                mem_write
);
    logic       rst_q;
    logic       wait_q;
    logic [1:0] sync_out;
    ctl_regs_t  regs_d;
    ctl_regs_t  regs_q;
    ctl_state_e next_state;
    strobes_t   strb;
    logic [STATE_W-1:0] state_q;

    ctl_in_sync #(.WIDTH(2), .STAGES(1)) u_sync (
        .clk     (clk),
        .async_i ({rst_in, mem_wait_in}),
        .sync_o  (sync_out)
    );
    assign rst_q  = sync_out[1];
    assign wait_q = sync_out[0];

    ctl_next_state u_next (
        .state_i  (regs_q.state),
        .rst_s_i  (rst_q),
        .wait_s_i (wait_q),
        .op_i     (ir_op),
        .sign_i   (acc_sign),
        .state_o  (next_state)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = next_state;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    ctl_strobe_dec u_dec (
        .state_i (regs_q.state),
        .strb_o  (strb)
    );

    assign state_q       = regs_q.state;
    assign ctl_state     = state_q;
    assign pc_clear      = strb.pc_clear;
    assign pc_incr       = strb.pc_incr;
    assign pc_to_mar     = strb.pc_to_mar;
    assign mbr_to_ir     = strb.mbr_to_ir;
    assign mbr_to_acc    = strb.mbr_to_acc;
    assign acc_to_mbr    = strb.acc_to_mbr;
    assign acc_add       = strb.acc_add;
    assign iraddr_to_mar = strb.iraddr_to_mar;
    assign iraddr_to_pc  = strb.iraddr_to_pc;
    assign mem_to_mbr    = strb.mem_to_mbr;
    assign mem_req       = strb.mem_req;
    assign mem_write     = strb.mem_write;
endmodule

// File: rtl/acc_ctrl_fsm_chk.sv
module acc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst_q,
    input logic       wait_q,
    input logic       mem_wait_in,
    input logic [1:0] ir_op,
    input logic       acc_sign,
    input logic [3:0] state_q,
    input logic       mem_req,
    input logic       mem_write,
    input logic       iraddr_to_pc
);
    logic armed_q = 1'b0;
    always_ff @(posedge clk) armed_q <= armed_q | rst_q;

    p_rst_prio_r2: assert property (@(posedge clk) disable iff (!armed_q)
        rst_q |=> state_q == 4'd0);

    p_res_exit_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == 4'd0 && !rst_q) |=> state_q == 4'd1);

    p_if1_hold_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == 4'd2 && !wait_q && !rst_q) |=> state_q == 4'd2);

    p_dispatch_ld_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == 4'd5 && !rst_q && ir_op == 2'b00) |=> state_q == 4'd6);

    p_dispatch_br_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == 4'd5 && !rst_q && ir_op == 2'b11) |=> state_q == 4'd14);

    p_write_in_st1_r6: assert property (@(posedge clk) disable iff (!armed_q)
        mem_write |-> (state_q == 4'd10 && mem_req));

    p_br_fall_r8: assert property (@(posedge clk) disable iff (!armed_q)
        (state_q == 4'd14 && !rst_q && !acc_sign) |=> state_q == 4'd1);

    p_wait_delay_r9: assert property (@(posedge clk) disable iff (!armed_q)
        wait_q == $past(mem_wait_in));

    p_pc_load_r10: assert property (@(posedge clk) disable iff (!armed_q)
        (iraddr_to_pc && !$past(rst_q)) |-> $past(state_q) == 4'd14);
endmodule

bind acc_ctrl_fsm acc_ctrl_fsm_chk u_chk (
    .clk          (clk),
    .rst_q        (rst_q),
    .wait_q       (wait_q),
    .mem_wait_in  (mem_wait_in),
    .ir_op        (ir_op),
    .acc_sign     (acc_sign),
    .state_q      (state_q),
    .mem_req      (mem_req),
    .mem_write    (mem_write),
    .iraddr_to_pc (iraddr_to_pc)
);

// File: tb/acc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module acc_ctrl_fsm_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_in = 1'b1, mem_wait_in = 1'b0, acc_sign = 1'b0;
    logic [1:0] ir_op = 2'b00;
    logic [3:0] ctl_state;
    logic pc_clear, pc_incr, pc_to_mar, mbr_to_ir, mbr_to_acc, acc_to_mbr;
    logic acc_add, iraddr_to_mar, iraddr_to_pc, mem_to_mbr, mem_req, mem_write;

    acc_ctrl_fsm u_dut (
        .clk(clk), .rst_in(rst_in), .mem_wait_in(mem_wait_in), .ir_op(ir_op),
        .acc_sign(acc_sign), .ctl_state(ctl_state), .pc_clear(pc_clear),
        .pc_incr(pc_incr), .pc_to_mar(pc_to_mar), .mbr_to_ir(mbr_to_ir),
        .mbr_to_acc(mbr_to_acc), .acc_to_mbr(acc_to_mbr), .acc_add(acc_add),
        .iraddr_to_mar(iraddr_to_mar), .iraddr_to_pc(iraddr_to_pc),
        .mem_to_mbr(mem_to_mbr), .mem_req(mem_req), .mem_write(mem_write)
    );

    localparam logic [3:0] RES=0, IF0=1, IF1=2, IF2=3, IF3=4, OD=5, LD0=6, LD1=7,
        LD2=8, ST0=9, ST1=10, AD0=11, AD1=12, AD2=13, BR0=14, BR1=15;

    // {rst, wait, op[1:0], sign, expected state after the edge}
    localparam int NV = 23;
    localparam logic [8:0] VECS [NV] = '{
        {1'b0,1'b0,2'b00,1'b0,RES}, {1'b0,1'b0,2'b00,1'b0,IF0},
        {1'b0,1'b0,2'b00,1'b0,IF1}, {1'b0,1'b1,2'b00,1'b0,IF1},
        {1'b0,1'b1,2'b00,1'b0,IF2}, {1'b0,1'b0,2'b00,1'b0,IF2},
        {1'b0,1'b0,2'b00,1'b0,IF3}, {1'b0,1'b0,2'b00,1'b0,OD},
        {1'b0,1'b0,2'b00,1'b0,LD0}, {1'b0,1'b1,2'b00,1'b0,LD1},
        {1'b0,1'b0,2'b00,1'b0,LD1}, {1'b0,1'b0,2'b00,1'b0,LD2},
        {1'b0,1'b0,2'b01,1'b0,IF0}, {1'b0,1'b0,2'b01,1'b0,IF1},
        {1'b0,1'b1,2'b01,1'b0,IF1}, {1'b0,1'b0,2'b01,1'b0,IF2},
        {1'b0,1'b0,2'b01,1'b0,IF3}, {1'b0,1'b0,2'b01,1'b0,OD},
        {1'b0,1'b0,2'b01,1'b0,ST0}, {1'b0,1'b1,2'b01,1'b0,ST1},
        {1'b0,1'b1,2'b01,1'b0,ST1}, {1'b0,1'b0,2'b01,1'b0,ST1},
        {1'b0,1'b0,2'b01,1'b0,IF0}
    };

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [11:0] strb;
    assign strb = {pc_clear, pc_incr, pc_to_mar, mbr_to_ir, mbr_to_acc, acc_to_mbr,
                   acc_add, iraddr_to_mar, iraddr_to_pc, mem_to_mbr, mem_req, mem_write};

    // Expected strobes per state, from R10
    function automatic logic [11:0] exp_strb(input logic [3:0] st);
        case (st)
            RES:           return 12'b1000_0000_0000;
            IF0:           return 12'b0110_0000_0000;
            IF1:           return 12'b0000_0000_0010;
            IF2, LD1, AD1: return 12'b0000_0000_0110;
            IF3:           return 12'b0001_0000_0000;
            LD0, AD0:      return 12'b0000_0001_0000;
            LD2:           return 12'b0000_1000_0000;
            ST0:           return 12'b0000_0101_0000;
            ST1:           return 12'b0000_0000_0011;
            AD2:           return 12'b0000_0010_0000;
            BR1:           return 12'b0000_0000_1000;
            default:       return 12'b0;
        endcase
    endfunction

    task automatic step(input logic r, input logic w, input logic [1:0] op, input logic s);
        rst_in = r; mem_wait_in = w; ir_op = op; acc_sign = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] es, input string tag);
        total++;
        if (ctl_state !== es) begin
            bad++;
            $display("FAIL %s state act=%0d exp=%0d", tag, ctl_state, es);
        end else if (strb !== exp_strb(es)) begin
            bad++;
            $display("FAIL R10 (%s) strobes act=%b exp=%b", tag, strb, exp_strb(es));
        end
    endtask

    // From IF0 with wait low: fetch, then dispatch on op
    task automatic fetch(input logic [1:0] op, input logic s, input logic [3:0] disp);
        step(0, 1, op, s); chk(IF1, "R3 fetch IF1");
        step(0, 0, op, s); chk(IF2, "R3 fetch IF2");
        step(0, 0, op, s); chk(IF3, "R3 fetch IF3");
        step(0, 0, op, s); chk(OD,  "R3 fetch OD");
        step(0, 0, op, s); chk(disp, "R4 dispatch");
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 2'b00, 0);
        step(1, 0, 2'b00, 0);
        step(1, 0, 2'b00, 0);
        chk(RES, "R2 reset state");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][8], VECS[i][7], VECS[i][6:5], VECS[i][4]);
            chk(VECS[i][3:0], $sformatf("R1 R3 R5 R6 R9 row %0d", i));
        end

        // add path (R7)
        fetch(2'b10, 0, AD0);
        step(0, 1, 2'b10, 0); chk(AD1, "R7 AD1");
        step(0, 0, 2'b10, 0); chk(AD1, "R7 AD1 hold");
        step(0, 0, 2'b10, 0); chk(AD2, "R7 AD2");
        step(0, 0, 2'b10, 0); chk(IF0, "R7 back to IF0");

        // branch not taken (R8)
        fetch(2'b11, 0, BR0);
        step(0, 0, 2'b11, 0); chk(IF0, "R8 branch not taken");

        // branch taken (R8), plus Moore check in OD (R10)
        step(0, 1, 2'b11, 1); chk(IF1, "R3 fetch IF1");
        step(0, 0, 2'b11, 1); chk(IF2, "R3 fetch IF2");
        step(0, 0, 2'b11, 1); chk(IF3, "R3 fetch IF3");
        step(0, 0, 2'b00, 0); chk(OD,  "R3 fetch OD");
        ir_op = 2'b01; acc_sign = 1'b1; #2; chk(OD, "R10 strobes ignore op change");
        ir_op = 2'b10; acc_sign = 1'b0; #2; chk(OD, "R10 strobes ignore sign change");
        step(0, 0, 2'b11, 1); chk(BR0, "R4 dispatch to BR0");
        step(0, 0, 2'b11, 1); chk(BR1, "R8 branch taken");
        step(0, 0, 2'b11, 1); chk(IF0, "R8 BR1 to IF0");

        // reset in mid handshake with wait held high (R2, R9)
        step(0, 1, 2'b00, 0); chk(IF1, "R3 IF1");
        step(0, 1, 2'b00, 0); chk(IF2, "R3 IF2");
        step(1, 1, 2'b00, 0); chk(IF2, "R2 reset one edge late");
        step(1, 1, 2'b00, 0); chk(RES, "R2 reset priority");
        step(0, 0, 2'b00, 0); chk(RES, "R2 release delayed");
        step(0, 0, 2'b00, 0); chk(IF0, "R2 RES to IF0");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule